// File: doc/BRIEF.md
# Serial FIFO Status and Error Flag Unit

This block watches the occupancy of a serial controller's 32-bit input (receive) and output (transmit) FIFOs, together with the word events around them. From these it keeps one operational status word, one FIFO error word and one serial-side error word. The status word combines live FIFO-level bits with sticky service-request and transfer-done bits. The error words record overrun and underrun events as sticky bits. Every sticky bit is cleared when the host writes a 1 to its position, so writing back a value that was read clears exactly the bits that were seen.

A transfer moves a programmed number of words. Each direction has a 2-bit mode field that picks the count register to use: code 0 (FIFO mode) uses the FIFO-mode count, and any other code (block mode) uses the block-mode count. While the controller runs, the unit counts the words accepted in each direction and raises a done flag when the count reaches the limit. A single level interrupt stays high while any enabled error bit, or any service or done bit, is set. The FIFO storage and the serial shifter lie outside this block. It sees only their levels and event strobes.

Top module: `serial_flag_unit`

## Requirements
- R1: While rst is high, and in the cycle after rst falls, every sticky status bit, every error bit, every enable bit and every count register is zero, and irq is low.
- R2: op_status bits 7 (input FIFO full, in_level == DEPTH), 6 (output FIFO full, out_level == DEPTH), 5 (input FIFO not empty) and 4 (output FIFO not empty) follow the levels in the same cycle. Writes to op_status have no effect on them.
- R3: op_status bit 9 (input service) sets one cycle after a cycle with run high and in_level >= 1. Bit 8 (output service) sets one cycle after a cycle with run high, out_level <= DEPTH/2 and the output word count below its active limit. A limit of zero never sets bit 8.
- R4: err_flags bit 2 sets after rx_word arrives while the input FIFO is full. Bit 3 sets after tx_need arrives with run high and out_level == 0. Bit 4 sets after host_pop arrives while the input FIFO is empty. Bit 5 sets after host_push arrives while the output FIFO is full. None of these bits sets when its condition does not hold.
- R5: serr_flags bit 1 sets after a cycle with clk_over high, and bit 0 sets after a cycle with clk_under high.
- R6: The sticky bits (op_status 11:8, err_flags 5:2, serr_flags 1:0) hold until written with 1. Writing 0 to a bit leaves it unchanged. When a set condition and a clearing write fall in the same cycle, the bit ends up set.
- R7: Register select codes on wr_sel: 0 op_status, 1 err_flags, 2 error enable, 3 serr_flags, 4 serial enable, 5 mode, 6 FIFO-mode word count, 7 block-mode word count. In the mode register, the input field is wr_data[13:12] and the output field is wr_data[11:10]. Field code 0 selects the FIFO-mode count as the limit, and any other code selects the block-mode count.
- R8: op_status bit 11 (input done) sets when the number of received words accepted during run (rx_word while not full) reaches the input limit. Bit 10 (output done) sets when the number of words served (tx_need during run with out_level != 0) reaches the output limit. Both word counts return to zero while run is low.
- R9: irq is high exactly when any of op_status 11:8 is set, or any err_flags bit is set with the matching error-enable bit (same bit positions), or any serr_flags bit is set with the matching serial-enable bit.
- R10: The enable bits gate only irq. An error bit is recorded whether or not it is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Controller is in its run state |
| in_level | input | LVL_W | Words held in the input FIFO |
| out_level | input | LVL_W | Words held in the output FIFO |
| rx_word | input | 1 | Shifter delivers a received word to the input FIFO |
| tx_need | input | 1 | Shifter requests a word from the output FIFO |
| host_push | input | 1 | Host writes a word into the output FIFO |
| host_pop | input | 1 | Host reads a word from the input FIFO |
| clk_over | input | 1 | Serial clock overrun event |
| clk_under | input | 1 | Serial clock underrun event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R7) |
| wr_data | input | 32 | Register write data |
| op_status | output | 32 | Operational status word |
| err_flags | output | 32 | FIFO error word |
| serr_flags | output | 32 | Serial-side error word |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker checks on every cycle that a full-FIFO arrival and an empty-FIFO request during run each leave their error bit set on the next cycle, even when a clearing write falls in the same cycle. It also checks that error bits never drop without a clearing write, that the input done flag rises only after an accepted word during run, and that a set service flag always drives irq. The bench sweeps every pair of FIFO levels against the live level bits. It sweeps every level against both service thresholds, and it runs word counts up to both limits in each mode. Only these scenarios show the value of each limit, the switch between count registers, and the masking of irq by the enables.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    typedef enum logic [2:0] {
        SEL_OPSTAT  = 3'd0,
        SEL_ERR     = 3'd1,
        SEL_ERR_EN  = 3'd2,
        SEL_SERR    = 3'd3,
        SEL_SERR_EN = 3'd4,
        SEL_MODE    = 3'd5,
        SEL_FCNT    = 3'd6,
        SEL_BCNT    = 3'd7
    } reg_sel_e;

    // operational status positions
    localparam int OP_IN_DONE  = 11;
    localparam int OP_OUT_DONE = 10;
    localparam int OP_IN_SVC   = 9;
    localparam int OP_OUT_SVC  = 8;
    localparam int OP_STICKY_LSB = 8;

    // error positions
    localparam int ERR_LSB = 2;
    localparam int ERR_MSB = 5;

    // mode fields
    localparam int MODE_IN_LSB  = 12;
    localparam int MODE_OUT_LSB = 10;

    typedef struct packed {
        logic out_ovr;
        logic in_udr;
        logic out_udr;
        logic in_ovr;
    } fifo_err_t;

    typedef struct packed {
        logic in_done;
        logic out_done;
        logic in_svc;
        logic out_svc;
    } op_sticky_t;

    function automatic logic uses_fifo_count(input logic [1:0] mode_code);
        return mode_code == 2'd0;
    endfunction

endpackage

// File: rtl/sfu_w1c_reg.sv
module sfu_w1c_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[b] <= 1'b0;
            else if (set[b])
                q[b] <= 1'b1;
            else if (clr_we && clr_data[b])
                q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/sfu_word_counter.sv
module sfu_word_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             done_hit,
    output logic             remaining
);
    logic [CNT_W-1:0] cnt;

    assign remaining = cnt < limit;
    assign done_hit  = step && remaining && ((cnt + 1'b1) == limit);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (step && remaining)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/serial_flag_unit.sv
module serial_flag_unit
    import sfu_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [LVL_W-1:0] in_level,
    input  logic [LVL_W-1:0] out_level,
    input  logic             rx_word,
    input  logic             tx_need,
    input  logic             host_push,
    input  logic             host_pop,
    input  logic             clk_over,
    input  logic             clk_under,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [31:0]      wr_data,
    output logic [31:0]      op_status,
    output logic [31:0]      err_flags,
    output logic [31:0]      serr_flags,
    output logic             irq
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);

    logic in_full, out_full, in_empty, out_empty;
    assign in_full   = in_level == FULL_LVL;
    assign out_full  = out_level == FULL_LVL;
    assign in_empty  = in_level == '0;
    assign out_empty = out_level == '0;

    // configuration
    logic [3:0]       err_en;
    logic [1:0]       serr_en;
    logic [1:0]       mode_in, mode_out;
    logic [CNT_W-1:0] fifo_cnt, blk_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_en   <= '0;
            serr_en  <= '0;
            mode_in  <= '0;
            mode_out <= '0;
            fifo_cnt <= '0;
            blk_cnt  <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_ERR_EN:  err_en   <= wr_data[ERR_MSB:ERR_LSB];
                SEL_SERR_EN: serr_en  <= wr_data[1:0];
                SEL_MODE: begin
                    mode_in  <= wr_data[MODE_IN_LSB +: 2];
                    mode_out <= wr_data[MODE_OUT_LSB +: 2];
                end
                SEL_FCNT:    fifo_cnt <= wr_data[CNT_W-1:0];
                SEL_BCNT:    blk_cnt  <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    logic [CNT_W-1:0] in_limit, out_limit;
    assign in_limit  = uses_fifo_count(mode_in)  ? fifo_cnt : blk_cnt;
    assign out_limit = uses_fifo_count(mode_out) ? fifo_cnt : blk_cnt;

    // word counters
    logic rx_step, tx_step;
    logic in_hit, out_hit, in_rem, out_rem;
    assign rx_step = run && rx_word && !in_full;
    assign tx_step = run && tx_need && !out_empty;

    sfu_word_counter #(.CNT_W(CNT_W)) u_in_cnt (
        .clk(clk), .rst(rst), .run(run), .step(rx_step), .limit(in_limit),
        .done_hit(in_hit), .remaining(in_rem)
    );
    sfu_word_counter #(.CNT_W(CNT_W)) u_out_cnt (
        .clk(clk), .rst(rst), .run(run), .step(tx_step), .limit(out_limit),
        .done_hit(out_hit), .remaining(out_rem)
    );

    // sticky operational flags
    op_sticky_t op_set, op_q;
    assign op_set.in_done  = in_hit;
    assign op_set.out_done = out_hit;
    assign op_set.in_svc   = run && !in_empty;
    assign op_set.out_svc  = run && (out_level <= HALF_LVL) && out_rem;

    sfu_w1c_reg #(.W(4)) u_op_reg (
        .clk(clk), .rst(rst), .set(op_set),
        .clr_we(wr_en && reg_sel_e'(wr_sel) == SEL_OPSTAT),
        .clr_data(wr_data[OP_IN_DONE:OP_STICKY_LSB]), .q(op_q)
    );

    // FIFO error flags
    fifo_err_t err_set, err_q;
    assign err_set.out_ovr = host_push && out_full;
    assign err_set.in_udr  = host_pop && in_empty;
    assign err_set.out_udr = run && tx_need && out_empty;
    assign err_set.in_ovr  = rx_word && in_full;

    sfu_w1c_reg #(.W(4)) u_err_reg (
        .clk(clk), .rst(rst), .set(err_set),
        .clr_we(wr_en && reg_sel_e'(wr_sel) == SEL_ERR),
        .clr_data(wr_data[ERR_MSB:ERR_LSB]), .q(err_q)
    );

    // serial-side error flags
    logic [1:0] serr_q;
    sfu_w1c_reg #(.W(2)) u_serr_reg (
        .clk(clk), .rst(rst), .set({clk_over, clk_under}),
        .clr_we(wr_en && reg_sel_e'(wr_sel) == SEL_SERR),
        .clr_data(wr_data[1:0]), .q(serr_q)
    );

    assign op_status  = {20'd0, op_q, in_full, out_full, !in_empty, !out_empty, 4'd0};
    assign err_flags  = {26'd0, err_q, 2'd0};
    assign serr_flags = {30'd0, serr_q};

    assign irq = (|op_q) || (|(err_q & err_en)) || (|(serr_q & serr_en));
endmodule

// File: rtl/serial_flag_unit_chk.sv
module serial_flag_unit_chk #(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [LVL_W-1:0] in_level,
    input logic [LVL_W-1:0] out_level,
    input logic             rx_word,
    input logic             tx_need,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic [31:0]      op_status,
    input logic [31:0]      err_flags,
    input logic             irq
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (err_flags == 32'd0 && op_status[11:8] == 4'd0 && !irq));

    // R4
    in_ovr_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_word && in_level == FULL_LVL) |=> err_flags[2]);

    // R4
    out_udr_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tx_need && out_level == '0) |=> err_flags[3]);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == 3'd1) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R8
    in_done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(op_status[11]) |-> $past(run && rx_word));

    // R9
    svc_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (op_status[9] || op_status[8]) |-> irq);
endmodule

bind serial_flag_unit serial_flag_unit_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .run(run), .in_level(in_level), .out_level(out_level),
    .rx_word(rx_word), .tx_need(tx_need), .wr_en(wr_en), .wr_sel(wr_sel),
    .op_status(op_status), .err_flags(err_flags), .irq(irq)
);

// File: tb/serial_flag_unit_tb.sv
`timescale 1ns/1ps
module serial_flag_unit_tb;
    localparam int DEPTH = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic [LVL_W-1:0] in_level = '0, out_level = '0;
    logic rx_word = 0, tx_need = 0, host_push = 0, host_pop = 0;
    logic clk_over = 0, clk_under = 0;
    logic wr_en = 0;
    logic [2:0] wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] op_status, err_flags, serr_flags;
    logic irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    serial_flag_unit #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .run(run), .in_level(in_level), .out_level(out_level),
        .rx_word(rx_word), .tx_need(tx_need), .host_push(host_push), .host_pop(host_pop),
        .clk_over(clk_over), .clk_under(clk_under), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .op_status(op_status), .err_flags(err_flags),
        .serr_flags(serr_flags), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1 op_status", op_status, 32'h0);
        chk("R1 err_flags", err_flags, 32'h0);
        chk("R1 serr_flags", serr_flags, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rst = 1'b0;
        tick();
        chk("R1 after release", {op_status[11:8], err_flags[5:2], 23'd0, irq}, 32'd0);

        // R2 live level bits, exhaustive over both levels
        for (int i = 0; i <= DEPTH; i++) begin
            for (int o = 0; o <= DEPTH; o++) begin
                in_level = LVL_W'(i); out_level = LVL_W'(o);
                #1;
                chk("R2 level bits", {28'd0, op_status[7:4]},
                    {28'd0, (i == DEPTH), (o == DEPTH), (i != 0), (o != 0)});
            end
        end
        in_level = LVL_W'(DEPTH); out_level = LVL_W'(DEPTH);
        wr(3'd0, 32'h0000_00F0);
        chk("R2 write ignored", {28'd0, op_status[7:4]}, 32'h0000_000F);

        // R3 input service sweep
        for (int l = 0; l <= DEPTH; l++) begin
            run = 0;
            wr(3'd0, 32'h0000_0F00);
            in_level = LVL_W'(l); out_level = LVL_W'(DEPTH);
            run = 1;
            tick();
            chk("R3 in svc", {30'd0, op_status[9], op_status[8]}, {30'd0, (l >= 1), 1'b0});
        end
        // R3 output service sweep with limit 4 (mode 0 uses FIFO-mode count, R7)
        run = 0;
        wr(3'd6, 32'd4);
        for (int l = 0; l <= DEPTH; l++) begin
            run = 0;
            wr(3'd0, 32'h0000_0F00);
            in_level = '0; out_level = LVL_W'(l);
            run = 1;
            tick();
            chk("R3 out svc", {31'd0, op_status[8]}, {31'd0, (l <= DEPTH / 2)});
        end
        // R3 limit zero never requests
        run = 0;
        wr(3'd6, 32'd0);
        wr(3'd0, 32'h0000_0F00);
        out_level = '0; run = 1;
        tick();
        chk("R3 zero limit", {31'd0, op_status[8]}, 32'd0);
        // R6 set wins over clearing write
        in_level = 1;
        tick();
        wr(3'd0, 32'h0000_0200);
        chk("R6 set wins", {31'd0, op_status[9]}, 32'd1);
        run = 0; in_level = '0;
        wr(3'd0, 32'h0000_0F00);
        chk("R6 op cleared", {28'd0, op_status[11:8]}, 32'd0);

        // R4 error classes
        in_level = 3; rx_word = 1; tick(); rx_word = 0;
        chk("R4 no in ovr when not full", err_flags, 32'h0);
        in_level = LVL_W'(DEPTH); rx_word = 1; tick(); rx_word = 0;
        chk("R4 in ovr", err_flags, 32'h4);
        wr(3'd1, 32'h3C);
        out_level = '0; run = 0; tx_need = 1; tick(); tx_need = 0;
        chk("R4 no out udr when stopped", err_flags, 32'h0);
        run = 1; tx_need = 1; tick(); tx_need = 0; run = 0;
        chk("R4 out udr", err_flags, 32'h8);
        wr(3'd1, 32'h3C);
        in_level = '0; host_pop = 1; tick(); host_pop = 0;
        chk("R4 in udr", err_flags, 32'h10);
        wr(3'd1, 32'h3C);
        out_level = LVL_W'(DEPTH); host_push = 1; tick(); host_push = 0;
        chk("R4 out ovr", err_flags, 32'h20);
        wr(3'd1, 32'h3C);
        chk("R6 err cleared", err_flags, 32'h0);

        // R5 serial errors
        clk_over = 1; tick(); clk_over = 0;
        chk("R5 clk over", serr_flags, 32'h2);
        clk_under = 1; tick(); clk_under = 0;
        chk("R5 clk under", serr_flags, 32'h3);

        // R6 partial clear and zero write
        in_level = LVL_W'(DEPTH); out_level = '0; run = 1;
        rx_word = 1; tx_need = 1; tick(); rx_word = 0; tx_need = 0; run = 0;
        wr(3'd0, 32'h0000_0F00);
        chk("R6 two set", err_flags, 32'h0C);
        wr(3'd1, 32'h04);
        chk("R6 partial clear", err_flags, 32'h08);
        wr(3'd1, 32'h00);
        chk("R6 zero write", err_flags, 32'h08);
        wr(3'd3, 32'h1);
        chk("R6 serr partial", serr_flags, 32'h2);

        // R9 / R10 irq masking
        chk("R10 disabled still recorded", {err_flags[3], 30'd0, irq}, {1'b1, 31'd0});
        wr(3'd2, 32'h08);
        chk("R9 err enabled irq", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'h08);
        chk("R9 irq drops", {31'd0, irq}, 32'd0);
        wr(3'd4, 32'h2);
        chk("R9 serr enabled irq", {31'd0, irq}, 32'd1);
        wr(3'd3, 32'h2);
        chk("R9 serr cleared", {31'd0, irq}, 32'd0);

        // R7 / R8 input done, FIFO-mode limit 3, block-mode limit 5
        wr(3'd6, 32'd3);
        wr(3'd7, 32'd5);
        wr(3'd5, 32'h0);
        in_level = 2; out_level = LVL_W'(DEPTH); run = 1; rx_word = 1;
        tick(); tick();
        chk("R8 in done early", {31'd0, op_status[11]}, 32'd0);
        tick();
        chk("R8 in done fifo", {31'd0, op_status[11]}, 32'd1);
        rx_word = 0; run = 0;
        wr(3'd0, 32'h0000_0F00);
        wr(3'd5, 32'h0000_1000);
        run = 1; rx_word = 1;
        repeat (4) tick();
        chk("R7 block limit early", {31'd0, op_status[11]}, 32'd0);
        tick();
        chk("R7 in done block", {31'd0, op_status[11]}, 32'd1);
        rx_word = 0; run = 0; in_level = '0;
        wr(3'd0, 32'h0000_0F00);

        // R7 / R8 output done
        wr(3'd5, 32'h0);
        out_level = 6; run = 1; tx_need = 1;
        tick(); tick();
        chk("R8 out done early", {31'd0, op_status[10]}, 32'd0);
        tick();
        chk("R8 out done fifo", {31'd0, op_status[10]}, 32'd1);
        tx_need = 0; run = 0;
        wr(3'd0, 32'h0000_0F00);
        wr(3'd5, 32'h0000_0400);
        run = 1; tx_need = 1;
        repeat (4) tick();
        chk("R7 out block early", {31'd0, op_status[10]}, 32'd0);
        tick();
        chk("R7 out done block", {31'd0, op_status[10]}, 32'd1);
        chk("R9 done drives irq", {31'd0, irq}, 32'd1);
        tx_need = 0; run = 0;
        tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule